// File: doc/BRIEF.md
# Multi-channel window threshold monitor

The block watches a stream of tagged conversion results and checks each one against a set of up to eight monitoring channels. Every channel names the source converter channel it follows, holds a 16-bit lower and upper limit, and keeps one status bit for an excursion below its window and one for an excursion above it. When a qualified excursion is latched, a level interrupt goes high and stays high until software clears the cause.

Software reaches the block through a byte-wide register bus with separate read and write strobes. Each monitoring channel owns an eight-byte slot, with slot n starting at 0x60 + 8*n. A global enable and a conversion-request register must both be set before any result is taken in. The converter, calibration arithmetic, temperature conversion and the measurement timer are outside the block: results arrive on a valid/tag/code input.

Top module: `thrmon_top`

## Requirements
- R1: After synchronous reset every slot byte, both status bitmaps, the global enable (0x46) and the conversion request (0x47) read 0x00, and the interrupt is low. Reads return data one clock after the read strobe edge.
- R2: Slot byte offsets are 0 source tag, 1/2 lower limit low/high byte, 3/4 upper limit low/high byte, 5 interval code in bits [1:0], 6 settle code in bits [3:0] and calibration select in bits [5:4], 7 enables (bit 7 measure, bit 1 upper-interrupt, bit 0 lower-interrupt). Unused bits read 0.
- R3: Results change no status bit unless bit 7 of 0x46 and bit 7 of 0x47 are both set.
- R4: A valid result updates every channel whose measure enable is set and whose source byte equals the result tag, and no other channel.
- R5: A code strictly below a channel's lower limit sets bit n of the lower-status bitmap at 0x0A; a code equal to the limit does not.
- R6: A code strictly above a channel's upper limit sets bit n of the upper-status bitmap at 0x0B; a code equal to the limit does not.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it; an excursion arriving in the same cycle as the clear keeps the bit set.
- R8: Clearing a channel's measure enable clears both its status bits, and a channel with measure enable low ignores results.
- R9: The interrupt is high when some channel has measure enable set together with a status bit whose matching interrupt enable is set; a status bit without its interrupt enable does not raise it.
- R10: The interrupt holds high across idle cycles until its cause is cleared.
- R11: Address 0x0F reads the number of channels (8) and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| res_valid | input | 1 | Result valid |
| res_tag | input | 8 | Source channel of the result |
| res_code | input | 16 | Result code |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a status clear that lands in the same clock as a fresh excursion on that channel, since it needs a bus write and a result in one cycle. The bench has a task that drives both strobes at the same falling edge and then reads the bitmap back to see the bit survive. Limit equality is reached by sending codes exactly on, and one step past, each limit, and tag sharing by pointing two channels at one source with different limits and interrupt enables.

// File: rtl/thrmon_pkg.sv
package thrmon_pkg;

    localparam int BUS_W  = 8;
    localparam int CODE_W = 16;
    localparam int TAG_W  = 8;

    localparam logic [7:0] A_STAT_LO = 8'h0A;
    localparam logic [7:0] A_STAT_HI = 8'h0B;
    localparam logic [7:0] A_COUNT   = 8'h0F;
    localparam logic [7:0] A_GEN     = 8'h46;
    localparam logic [7:0] A_CONV    = 8'h47;

    localparam int ARM_BIT   = 7;
    localparam int MEAS_BIT  = 7;
    localparam int HI_IE_BIT = 1;
    localparam int LO_IE_BIT = 0;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STLO,
        ACC_STHI,
        ACC_COUNT,
        ACC_GEN,
        ACC_CONV,
        ACC_SLOT
    } acc_e;

    typedef struct packed {
        logic [TAG_W-1:0]  src;
        logic [CODE_W-1:0] lo_lim;
        logic [CODE_W-1:0] hi_lim;
        logic [1:0]        ivl;
        logic [1:0]        cal;
        logic [3:0]        settle;
        logic              meas_en;
        logic              hi_ie;
        logic              lo_ie;
    } slot_t;

    function automatic slot_t slot_wr(slot_t s, logic [2:0] off, logic [BUS_W-1:0] d);
        slot_t r;
        r = s;
        case (off)
            3'd0: r.src          = d;
            3'd1: r.lo_lim[7:0]  = d;
            3'd2: r.lo_lim[15:8] = d;
            3'd3: r.hi_lim[7:0]  = d;
            3'd4: r.hi_lim[15:8] = d;
            3'd5: r.ivl          = d[1:0];
            3'd6: begin
                r.settle = d[3:0];
                r.cal    = d[5:4];
            end
            default: begin
                r.meas_en = d[MEAS_BIT];
                r.hi_ie   = d[HI_IE_BIT];
                r.lo_ie   = d[LO_IE_BIT];
            end
        endcase
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] slot_rd(slot_t s, logic [2:0] off);
        logic [BUS_W-1:0] r;
        case (off)
            3'd0: r = s.src;
            3'd1: r = s.lo_lim[7:0];
            3'd2: r = s.lo_lim[15:8];
            3'd3: r = s.hi_lim[7:0];
            3'd4: r = s.hi_lim[15:8];
            3'd5: r = {6'b0, s.ivl};
            3'd6: r = {2'b0, s.cal, s.settle};
            default: r = {s.meas_en, 5'b0, s.hi_ie, s.lo_ie};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thrmon_decode.sv
module thrmon_decode
    import thrmon_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter logic [7:0]  SLOT_BASE = 8'h60,
    localparam int unsigned CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [7:0]      addr,
    output acc_e            kind,
    output logic [CH_W-1:0] ch,
    output logic [2:0]      off
);
    localparam logic [8:0] SPAN = 9'(NCH * 8);

    logic [8:0] rel;

    always_comb begin
        rel  = {1'b0, addr} - {1'b0, SLOT_BASE};
        ch   = rel[3 +: CH_W];
        off  = rel[2:0];
        kind = ACC_NONE;
        if (addr >= SLOT_BASE && rel < SPAN) begin
            kind = ACC_SLOT;
        end else begin
            case (addr)
                A_STAT_LO: kind = ACC_STLO;
                A_STAT_HI: kind = ACC_STHI;
                A_COUNT:   kind = ACC_COUNT;
                A_GEN:     kind = ACC_GEN;
                A_CONV:    kind = ACC_CONV;
                default:   kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/thrmon_chan.sv
module thrmon_chan
    import thrmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [CODE_W-1:0] res_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_off,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              clr_lo,
    input  logic              clr_hi,
    output slot_t             cfg,
    output logic              st_lo,
    output logic              st_hi,
    output logic              evt
);
    slot_t cfg_q, cfg_d;
    logic  st_lo_q, st_hi_q;
    logic  match, trip_lo, trip_hi;

    always_comb begin
        cfg_d   = wr_en ? slot_wr(cfg_q, wr_off, wr_data) : cfg_q;
        match   = res_valid && armed && cfg_q.meas_en && (cfg_q.src == res_tag);
        trip_lo = match && (res_code < cfg_q.lo_lim);
        trip_hi = match && (res_code > cfg_q.hi_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            st_lo_q <= 1'b0;
            st_hi_q <= 1'b0;
        end else begin
            cfg_q   <= cfg_d;
            // a set in the same cycle as a clear wins; disabling wipes both
            st_lo_q <= cfg_d.meas_en && ((st_lo_q && !clr_lo) || trip_lo);
            st_hi_q <= cfg_d.meas_en && ((st_hi_q && !clr_hi) || trip_hi);
        end
    end

    assign cfg   = cfg_q;
    assign st_lo = st_lo_q;
    assign st_hi = st_hi_q;
    assign evt   = cfg_q.meas_en && ((st_lo_q && cfg_q.lo_ie) || (st_hi_q && cfg_q.hi_ie));

    // R8: no status survives while measurement is off
    a_r8_status_needs_meas: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.meas_en |-> (!st_lo_q && !st_hi_q));

    // R3: disarmed block never raises a status bit
    a_r3_no_set_disarmed: assert property (@(posedge clk) disable iff (rst)
        (!armed && !st_lo_q && !st_hi_q) |=> (!st_lo_q && !st_hi_q));

    // R4: without a matching result or a bus access the status is frozen
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!match && !wr_en && !clr_lo && !clr_hi) |=> ($stable(st_lo_q) && $stable(st_hi_q)));

    // R5 / R6: a trip with no slot write lands in the status bit
    a_r5_low_trip: assert property (@(posedge clk) disable iff (rst)
        (trip_lo && !wr_en) |=> st_lo_q);
    a_r6_high_trip: assert property (@(posedge clk) disable iff (rst)
        (trip_hi && !wr_en) |=> st_hi_q);

    // R7: a clear without a new trip empties the bit
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_lo && !trip_lo) |=> !st_lo_q);
endmodule

// File: rtl/thrmon_top.sv
module thrmon_top
    import thrmon_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter logic [7:0]  SLOT_BASE = 8'h60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [CODE_W-1:0] res_code,
    output logic              irq
);
    // status bitmaps are one byte wide, so NCH is limited to BUS_W
    localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    acc_e            kind;
    logic [CH_W-1:0] ch;
    logic [2:0]      off;
    logic            gen_en_q, conv_q, armed;
    logic [NCH-1:0]  st_lo_v, st_hi_v, evt_v;
    slot_t           cfg_a [NCH];
    logic [BUS_W-1:0] rd_mux, rdata_q;

    thrmon_decode #(.NCH(NCH), .SLOT_BASE(SLOT_BASE)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .ch   (ch),
        .off  (off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en_q <= 1'b0;
            conv_q   <= 1'b0;
        end else if (bus_we) begin
            if (kind == ACC_GEN)  gen_en_q <= bus_wdata[ARM_BIT];
            if (kind == ACC_CONV) conv_q   <= bus_wdata[ARM_BIT];
        end
    end

    assign armed = gen_en_q && conv_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        thrmon_chan u_ch (
            .clk       (clk),
            .rst       (rst),
            .armed     (armed),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_code  (res_code),
            .wr_en     (bus_we && kind == ACC_SLOT && ch == CH_W'(i)),
            .wr_off    (off),
            .wr_data   (bus_wdata),
            .clr_lo    (bus_we && kind == ACC_STLO && bus_wdata[i]),
            .clr_hi    (bus_we && kind == ACC_STHI && bus_wdata[i]),
            .cfg       (cfg_a[i]),
            .st_lo     (st_lo_v[i]),
            .st_hi     (st_hi_v[i]),
            .evt       (evt_v[i])
        );
    end

    always_comb begin
        case (kind)
            ACC_STLO:  rd_mux = BUS_W'(st_lo_v);
            ACC_STHI:  rd_mux = BUS_W'(st_hi_v);
            ACC_COUNT: rd_mux = BUS_W'(NCH);
            ACC_GEN:   rd_mux = {gen_en_q, 7'b0};
            ACC_CONV:  rd_mux = {conv_q, 7'b0};
            ACC_SLOT:  rd_mux = slot_rd(cfg_a[ch], off);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |evt_v;

    // R9: the interrupt always has a latched status behind it
    a_r9_irq_has_status: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((st_lo_v | st_hi_v) != '0));

    // R10: with no bus write the interrupt cannot drop
    a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !bus_we) |=> irq);
endmodule

// File: tb/thrmon_top_tb.sv
module thrmon_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        res_valid = 1'b0;
    logic [7:0]  res_tag = '0;
    logic [15:0] res_code = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] q_exp [$];
    string      q_req [$];
    logic       rd_flag = 1'b0;

    always #10 clk = ~clk;

    thrmon_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .res_valid(res_valid), .res_tag(res_tag), .res_code(res_code), .irq(irq)
    );

    // monitor: a read strobe seen at an edge yields data checked at the next falling edge
    always @(posedge clk) rd_flag <= bus_re;

    always @(negedge clk) begin
        if (rd_flag) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_fail++;
                $display("FAIL read with no expectation: got %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: read %02h expected %02h", r, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string r);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        q_exp.push_back(e);
        q_req.push_back(r);
        @(negedge clk);
        bus_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] t, input logic [15:0] c);
        @(negedge clk);
        res_tag = t; res_code = c; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // bus write and result in one and the same cycle
    task automatic wr_and_send(input logic [7:0] a, input logic [7:0] d,
                               input logic [7:0] t, input logic [15:0] c);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        res_tag = t; res_code = c; res_valid = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; res_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string r);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq %0b expected %0b", r, irq, e);
        end
    endtask

    task automatic cfg_slot(input int n, input logic [7:0] src, input logic [15:0] lo,
                            input logic [15:0] hi, input logic [7:0] en);
        logic [7:0] b;
        b = 8'h60 + 8'(n * 8);
        wr(b + 8'd0, src);
        wr(b + 8'd1, lo[7:0]);
        wr(b + 8'd2, lo[15:8]);
        wr(b + 8'd3, hi[7:0]);
        wr(b + 8'd4, hi[15:8]);
        wr(b + 8'd7, en);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd_expect(8'h0A, 8'h00, "R1 status low after reset");
        rd_expect(8'h0B, 8'h00, "R1 status high after reset");
        rd_expect(8'h46, 8'h00, "R1 global enable after reset");
        rd_expect(8'h47, 8'h00, "R1 conv request after reset");
        rd_expect(8'h67, 8'h00, "R1 slot0 enables after reset");
        rd_expect(8'h9B, 8'h00, "R1 slot7 upper limit after reset");

        // R11 channel count, read only
        rd_expect(8'h0F, 8'h08, "R11 channel count");
        wr(8'h0F, 8'h03);
        rd_expect(8'h0F, 8'h08, "R11 count ignores write");

        // R2 slot layout and masked fields
        cfg_slot(0, 8'h05, 16'h1000, 16'h8000, 8'h83);
        rd_expect(8'h60, 8'h05, "R2 slot0 source");
        rd_expect(8'h62, 8'h10, "R2 slot0 lower limit high byte");
        rd_expect(8'h64, 8'h80, "R2 slot0 upper limit high byte");
        rd_expect(8'h67, 8'h83, "R2 slot0 enables");
        wr(8'h9D, 8'hFF);
        wr(8'h9E, 8'hFF);
        wr(8'h9F, 8'hFF);
        rd_expect(8'h9D, 8'h03, "R2 interval field masked");
        rd_expect(8'h9E, 8'h3F, "R2 control field masked");
        rd_expect(8'h9F, 8'h83, "R2 enable field masked");
        wr(8'h9F, 8'h00);

        // R3 arming
        send(8'h05, 16'h0001);
        rd_expect(8'h0A, 8'h00, "R3 ignored with nothing armed");
        wr(8'h46, 8'h80);
        send(8'h05, 16'h0001);
        rd_expect(8'h0A, 8'h00, "R3 ignored with only global enable");
        wr(8'h47, 8'h80);
        send(8'h05, 16'h0001);
        rd_expect(8'h0A, 8'h01, "R5 below lower limit sets bit0");
        chk_irq(1'b1, "R9 irq from lower status");

        // R10 hold over idle cycles
        repeat (10) @(negedge clk);
        chk_irq(1'b1, "R10 irq holds while idle");

        // R7 write-one-to-clear
        wr(8'h0A, 8'h00);
        rd_expect(8'h0A, 8'h01, "R7 writing zero keeps bit");
        wr(8'h0A, 8'h01);
        rd_expect(8'h0A, 8'h00, "R7 writing one clears bit");
        chk_irq(1'b0, "R10 irq drops after clear");

        // R5 / R6 boundaries
        send(8'h05, 16'h1000);
        rd_expect(8'h0A, 8'h00, "R5 equal to lower limit no trip");
        send(8'h05, 16'h0FFF);
        rd_expect(8'h0A, 8'h01, "R5 one below lower limit trips");
        wr(8'h0A, 8'h01);
        send(8'h05, 16'h8000);
        rd_expect(8'h0B, 8'h00, "R6 equal to upper limit no trip");
        send(8'h05, 16'h8001);
        rd_expect(8'h0B, 8'h01, "R6 one above upper limit trips");
        chk_irq(1'b1, "R9 irq from upper status");
        wr(8'h0B, 8'h01);
        chk_irq(1'b0, "R7 upper clear drops irq");

        // R4 shared tag, R9 enable qualification
        cfg_slot(3, 8'h05, 16'h2000, 16'h3000, 8'h80);
        cfg_slot(2, 8'h06, 16'h0000, 16'hFFFF, 8'h83);
        send(8'h05, 16'h1800);
        rd_expect(8'h0A, 8'h08, "R4 only ch3 window crossed");
        chk_irq(1'b0, "R9 status without interrupt enable");
        send(8'h05, 16'h0800);
        rd_expect(8'h0A, 8'h09, "R4 both channels on tag 5 trip");
        chk_irq(1'b1, "R9 irq from ch0");
        send(8'h07, 16'h0000);
        rd_expect(8'h0A, 8'h09, "R4 unmatched tag changes nothing");

        // R8 measurement disable
        wr(8'h67, 8'h03);
        rd_expect(8'h0A, 8'h08, "R8 disable clears ch0 status");
        chk_irq(1'b0, "R8 irq gone with ch0 disabled");
        send(8'h05, 16'h0100);
        rd_expect(8'h0A, 8'h08, "R8 disabled ch0 ignores result");

        // R7 new trip in the clearing cycle wins
        wr_and_send(8'h0A, 8'h08, 8'h05, 16'h0100);
        rd_expect(8'h0A, 8'h08, "R7 same-cycle trip survives clear");
        wr(8'h0A, 8'h08);
        rd_expect(8'h0A, 8'h00, "R7 later clear empties bit");

        repeat (3) @(negedge clk);
        n_chk++;
        if (q_exp.size() != 0) begin
            n_fail++;
            $display("FAIL R1 scoreboard: %0d reads pending expected 0", q_exp.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule